// File: doc/BRIEF.md
# Two-Wire Receive Slave with High-Speed Entry

This block is the protocol core of a write-oriented two-wire serial slave. It samples the bus clock and data lines with the system clock and recognises bus start, repeated start and stop conditions. It shifts in address and data bytes, and it answers to a 7-bit device address whose lowest bit comes from a strap pin. Each accepted write byte appears on a parallel output for one clock.

The first byte after a start can also be the high-speed master code. The block takes that code without acknowledging it and raises a flag. An input filter stage outside the block can use the flag to switch to faster filtering. The flag survives repeated starts and clears on stop.

A general-call address followed by the reset command byte makes the block emit a one-clock reset pulse. The pad, the analog filters and any register file fed by the data output lie outside the block. The block pulls data low only through an output enable and has no clock output.

Top module: `i2c_hs_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1110 10 followed by the level of `addr_lsb`. With the strap low it answers 0x74 (write byte 0xE8). With the strap high it answers 0x75 (write byte 0xEA). Acknowledge means `sda_oe` high during the ninth clock.
- R2: An address byte that does not match is not acknowledged. The data bytes that follow it produce no acknowledge and no `rx_valid` until the next start.
- R3: After a matched write address, every data byte is received MSB first on SCL rising edges and acknowledged. It is presented on `rx_data` with a `rx_valid` pulse lasting exactly one clock.
- R4: Data falling while SCL is high is a start, and data rising while SCL is high is a stop. A repeated start begins a new address phase. A stop returns the slave to idle.
- R5: A first byte of the form 00001xxx is the high-speed code, for any value of the three low bits. It is never acknowledged, and `hs_mode` rises after its ninth clock.
- R6: `hs_mode` stays set across repeated starts, so that addressed transfers still work without a new code. It clears on the next stop.
- R7: General-call address 0x00 is acknowledged. A following data byte of 0x06 produces a one-clock `dev_reset` pulse, and any other value produces none. General-call bytes never appear on `rx_valid`.
- R8: A read request (R/W bit 1) to the matched address is acknowledged. The following byte is left released, so the master reads 0xFF.
- R9: `sda_oe` changes only while the synchronised SCL is low.
- R10: After reset, `sda_oe`, `hs_mode`, `rx_valid` and `dev_reset` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_lsb | input | 1 | Strap that sets the address LSB |
| sda_oe | output | 1 | Pull data line low when high |
| hs_mode | output | 1 | High-speed mode active |
| rx_valid | output | 1 | One-clock strobe for a received write byte |
| rx_data | output | 8 | Received write byte |
| dev_reset | output | 1 | One-clock general-call reset pulse |

## Verification
The bench builds the block with its default parameters: address prefix 111010 and reset command 0x06. These defaults make both strap settings, the high-speed code and the general-call reset reachable with ordinary byte sequences. The bus model is a wired-AND of the master's data and the slave's enable. It holds each SCL phase for eight system clocks, so the three-stage sampling and the acknowledge timing are exercised close to the minimum oversampling ratio.

// File: rtl/i2c_hs_slave.sv
module i2c_hs_slave #(
  parameter logic [5:0] ADDR_HI = 6'b111010,
  parameter logic [4:0] HS_PFX  = 5'b00001,
  parameter logic [7:0] GC_CMD  = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_lsb,
  output logic       sda_oe,
  output logic       hs_mode,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       dev_reset
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WR, S_RD} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [6:0] sh;
  logic       ack_nx, hs_hit, gc, rw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_s   = scl_q[1];
  wire scl_d   = scl_q[2];
  wire rise    = scl_s & ~scl_d;
  wire fall    = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_q[2] & ~sda_q[1];
  wire stop_c  = scl_s & scl_d & ~sda_q[2] & sda_q[1];
  wire [7:0] byte_in = {sh, sda_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0;
      ack_nx <= 1'b0; hs_hit <= 1'b0; gc <= 1'b0; rw <= 1'b0;
      sda_oe <= 1'b0; hs_mode <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0; dev_reset <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      dev_reset <= 1'b0;
      if (stop_c) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0; hs_mode <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (st == S_ADDR || st == S_WR) begin
        if (rise && cnt < 4'd8) begin
          sh  <= byte_in[6:0];
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            if (st == S_ADDR) begin
              hs_hit <= byte_in[7:3] == HS_PFX;
              gc     <= byte_in == 8'h00;
              rw     <= byte_in[0];
              ack_nx <= (byte_in[7:1] == {ADDR_HI, addr_lsb}) || (byte_in == 8'h00);
            end else begin
              ack_nx <= 1'b1;
              if (gc) dev_reset <= byte_in == GC_CMD;
              else begin
                rx_valid <= 1'b1;
                rx_data  <= byte_in;
              end
            end
          end
        end else if (fall && cnt == 4'd8) begin
          sda_oe <= ack_nx;
          cnt    <= 4'd9;
        end else if (fall && cnt == 4'd9) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          if (st == S_ADDR) begin
            if (hs_hit) begin
              hs_mode <= 1'b1;
              st      <= S_IDLE;
            end else if (!ack_nx) st <= S_IDLE;
            else if (rw)          st <= S_RD;
            else                  st <= S_WR;
          end
        end
      end
    end

  AST_OE_SCL_LOW:  assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_s);       // R9
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) st == S_IDLE |-> !sda_oe);          // R2
  AST_RX_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);           // R3
  AST_HS_NO_ACK:   assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_mode) |-> !sda_oe);       // R5
  AST_HS_STOP:     assert property (@(posedge clk) disable iff (!rst_n) stop_c |=> !hs_mode);              // R6
  AST_RST_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) dev_reset |=> !dev_reset);         // R7
  AST_RST_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(dev_reset && rx_valid));         // R7
  AST_RD_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) st == S_RD |-> !sda_oe);            // R8

endmodule

// File: tb/i2c_hs_slave_test.sv
`timescale 1ns/1ps
module i2c_hs_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe, hs_mode, rx_valid, dev_reset;
  logic [7:0] rx_data;
  wire sda_line = sda_m & ~sda_oe;

  int errs = 0, checks = 0, nrst = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  i2c_hs_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_lsb(strap),
    .sda_oe(sda_oe), .hs_mode(hs_mode), .rx_valid(rx_valid), .rx_data(rx_data),
    .dev_reset(dev_reset));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rx_valid", int'(rx_data), 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(rx_data == e, "R3 rx_data", int'(rx_data), int'(e));
      end
    end
    if (dev_reset) nrst++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(2);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic xfer(input logic [7:0] d, output logic ack, output logic [7:0] rd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = d[i]; tick(Q); scl_m = 1'b1; tick(Q / 2); rd[i] = sda_line; tick(Q / 2);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q / 2); ack = ~sda_line; tick(Q / 2);
    scl_m = 1'b0; tick(Q);
  endtask

  logic a;
  logic [7:0] r;

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tick(4);
    chk(!sda_oe && !hs_mode && !rx_valid && !dev_reset, "R10 reset outputs", {sda_oe, hs_mode, rx_valid, dev_reset}, 0);
    rst_n = 1'b1; tick(4);

    // R1 strap low, address 0x74 write; R3 data bytes
    strap = 1'b0;
    bstart(); xfer(8'hE8, a, r); chk(a, "R1 ack 0x74", a, 1);
    exp_q.push_back(8'hA5); xfer(8'hA5, a, r); chk(a, "R3 ack data", a, 1);
    exp_q.push_back(8'h3C); xfer(8'h3C, a, r); chk(a, "R3 ack data", a, 1);
    bstop(); chk(!hs_mode, "R4 idle after stop", hs_mode, 0);

    // R2 mismatch (0x75 while strap low): no ack, data ignored
    bstart(); xfer(8'hEA, a, r); chk(!a, "R2 no ack mismatch", a, 0);
    xfer(8'h55, a, r); chk(!a, "R2 data ignored", a, 0);
    bstop();
    bstart(); xfer(8'h10, a, r); chk(!a, "R2 reserved byte no ack", a, 0); bstop();

    // R1 strap high, 0x75
    strap = 1'b1; tick(4);
    bstart(); xfer(8'hEA, a, r); chk(a, "R1 ack 0x75", a, 1);
    exp_q.push_back(8'h81); xfer(8'h81, a, r); chk(a, "R3 ack data", a, 1);
    bstop();

    // R5 Hs code, R6 kept across repeated start
    bstart(); xfer(8'h0B, a, r); chk(!a, "R5 hs code not acked", a, 0);
    chk(hs_mode, "R5 hs_mode set", hs_mode, 1);
    bstart(); xfer(8'hEA, a, r); chk(a, "R6 ack after rep start", a, 1);
    exp_q.push_back(8'h12); xfer(8'h12, a, r);
    chk(hs_mode, "R6 hs_mode kept", hs_mode, 1);
    bstart(); xfer(8'hEA, a, r); chk(a, "R4 rep start readdress", a, 1);
    exp_q.push_back(8'h34); xfer(8'h34, a, r);
    chk(hs_mode, "R6 hs_mode kept twice", hs_mode, 1);
    bstop(); tick(2); chk(!hs_mode, "R6 hs_mode cleared on stop", hs_mode, 0);
    bstart(); xfer(8'h08, a, r); chk(!a && hs_mode, "R5 hs code low bits 000", {a, hs_mode}, 1);
    bstop(); tick(2); chk(!hs_mode, "R6 clear again", hs_mode, 0);

    // R7 general call reset
    bstart(); xfer(8'h00, a, r); chk(a, "R7 gc ack", a, 1);
    xfer(8'h06, a, r); chk(a && nrst == 1, "R7 reset pulse", nrst, 1);
    bstop();
    bstart(); xfer(8'h00, a, r); xfer(8'h05, a, r); bstop();
    chk(nrst == 1, "R7 no pulse for 0x05", nrst, 1);

    // R8 read returns 0xFF
    bstart(); xfer(8'hEB, a, r); chk(a, "R8 read ack", a, 1);
    xfer(8'hFF, a, r); chk(r == 8'hFF, "R8 read data released", r, 8'hFF);
    bstop();

    tick(20);
    chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule